// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the target side of a two-wire serial memory that can only be read from the bus. It oversamples the clock and data lines through synchronizers and finds the bus conditions and clock edges. It pulls the data line low through an open-drain enable output. A persistent word pointer selects which byte of an on-chip byte array goes out next. A sideband write port loads the array. Nothing on the bus can change the array contents.

A master reads in one of three ways. The first reads at the pointer. The second loads the pointer with an address-only write and then reads after a repeated START. The third keeps acknowledging bytes so that the pointer walks forward and wraps at the end of the array. Any read ends when the master does not acknowledge. After that the block waits for a STOP or a fresh START.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: After reset the data line is released and the word pointer is 0, so the first read at the pointer returns byte 0.
- R2: The block acknowledges a device byte (SDA low on its ninth clock) when bits 7..4 are 1010 and bits 3..1 equal strap_i. Bit 0 is the read/write flag, with 1 meaning read.
- R3: A device byte that does not match gets no acknowledge, and SDA stays released until the next START.
- R4: A read at the pointer shifts out the byte at the pointer MSB first. Each byte sent moves the pointer up by one.
- R5: After a device byte with bit 0 = 0, the block acknowledges two address bytes (high byte, then low byte). At the end of the second acknowledge the pointer is loaded with the low bits of that 16-bit value, and the upper bits are ignored. A read after a repeated START returns the byte at the loaded address.
- R6: A master acknowledge (SDA low) on the ninth clock of a sent byte makes the block send the following byte.
- R7: The pointer wraps from DEPTH-1 to 0.
- R8: A master non-acknowledge (SDA high) on the ninth clock ends the read and leaves SDA released. A following STOP or START is accepted.
- R9: A START or STOP at any point resets the bit count and state and releases SDA. An aborted address load leaves the pointer unchanged.
- R10: The block changes its SDA drive only while SCL is low.
- R11: A sideband write stores bd_data_i at bd_addr_i, and a later bus read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Device select bits matched against device byte bits 3..1 |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| bd_we_i | input | 1 | Sideband write enable |
| bd_addr_i | input | AW | Sideband write address |
| bd_data_i | input | 8 | Sideband write data |

## Verification
The read path is driven with pointer reads, random reads at ordinary addresses, random reads with junk in the unused high address bits, and sequential runs that cross the end of the array. Together these separate a pointer that keeps its value from one that was reloaded, truncated from full address decoding, and wrapped from overflowing. Separate patterns cover a foreign device byte, a STOP or repeated START inside an address byte, and a non-acknowledge followed straight by START. These show that abort paths neither drive the line nor disturb the pointer. A sideband-written byte read back over the bus ties the array port to the read path.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_HI, ST_ACK_HI,
    ST_LO, ST_ACK_LO, ST_TX, ST_MACK
  } rd_state_e;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign sda_o   = sda_ff[1];
  assign rise_o  = scl_ff[1] & ~scl_q;
  assign fall_o  = ~scl_ff[1] & scl_q;
  assign start_o = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          sda_oe_o,
  output logic          tx_load_o
);
  rd_state_e   state_q;
  logic [3:0]  bit_q;
  logic [7:0]  rx_q, tx_q, hi_q;
  logic [15:0] word_w;
  logic        rw_q, mack_q, oe_q;
  logic [AW-1:0] addr_q;

  assign word_w    = {hi_q, rx_q};
  assign tx_load_o = fall_i & ~start_i & ~stop_i &
                     (((state_q == ST_ACK_DEV) & rw_q) | ((state_q == ST_MACK) & mack_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      hi_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      addr_q  <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_DEV;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (tx_load_o) begin
      tx_q    <= rd_data_i;
      oe_q    <= ~rd_data_i[7];
      addr_q  <= addr_q + 1'b1;
      bit_q   <= '0;
      state_q <= ST_TX;
    end else begin
      unique case (state_q)
        ST_DEV, ST_HI, ST_LO: begin
          if (rise_i) begin
            rx_q  <= {rx_q[6:0], sda_i};
            bit_q <= bit_q + 1'b1;
          end else if (fall_i && bit_q == 4'd8) begin
            bit_q <= '0;
            if (state_q == ST_DEV) begin
              if (rx_q[7:1] == {DEV_PREFIX, strap_i}) begin
                rw_q    <= rx_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ACK_DEV;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_HI) begin
              hi_q    <= rx_q;
              oe_q    <= 1'b1;
              state_q <= ST_ACK_HI;
            end else begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK_LO;
            end
          end
        end
        ST_ACK_DEV: if (fall_i) begin  // write direction: address bytes follow
          oe_q    <= 1'b0;
          state_q <= ST_HI;
        end
        ST_ACK_HI: if (fall_i) begin
          oe_q    <= 1'b0;
          state_q <= ST_LO;
        end
        ST_ACK_LO: if (fall_i) begin
          oe_q    <= 1'b0;
          addr_q  <= word_w[AW-1:0];
          state_q <= ST_IDLE;
        end
        ST_TX: if (fall_i) begin
          if (bit_q == 4'd7) begin
            oe_q    <= 1'b0;
            state_q <= ST_MACK;
          end else begin
            oe_q  <= ~tx_q[6];
            tx_q  <= {tx_q[6:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_MACK: begin
          if (rise_i) mack_q <= ~sda_i;
          else if (fall_i) state_q <= ST_IDLE;  // NACK ends the read
        end
        default: ;
      endcase
    end
  end

  assign addr_o   = addr_q;
  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    strap_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          bd_we_i,
  input  logic [AW-1:0] bd_addr_i,
  input  logic [7:0]    bd_data_i
);
  logic          sda_s, start_w, stop_w, rise_w, fall_w, tx_load_w;
  logic [AW-1:0] addr_w;
  logic [7:0]    rd_data_w;

  i2c_rd_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .start_o(start_w), .stop_o(stop_w),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  i2c_rd_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i, .we_i(bd_we_i), .waddr_i(bd_addr_i), .wdata_i(bd_data_i),
    .raddr_i(addr_w), .rdata_o(rd_data_w)
  );

  i2c_rd_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni, .start_i(start_w), .stop_i(stop_w),
    .rise_i(rise_w), .fall_i(fall_w), .sda_i(sda_s), .strap_i,
    .rd_data_i(rd_data_w), .addr_o(addr_w), .sda_oe_o, .tx_load_o(tx_load_w)
  );
endmodule

// File: rtl/i2c_eeprom_rd_chk.sv
module i2c_eeprom_rd_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          start_w,
  input logic          stop_w,
  input logic          tx_load_w,
  input logic [AW-1:0] addr_w
);
  assert_reset_release_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !sda_oe_o);

  assert_oe_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  assert_stop_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_o);

  assert_start_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !sda_oe_o);

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_w |=> addr_w == AW'($past(addr_w) + 1'b1));

  assert_addr_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_w && addr_w == '1) |=> addr_w == '0);
endmodule

bind i2c_eeprom_rd i2c_eeprom_rd_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o,
  .start_w, .stop_w, .tx_load_w, .addr_w
);

// File: tb/i2c_eeprom_rd_tb.sv
module i2c_eeprom_rd_tb;
  localparam int DEPTH = 256;
  localparam int Q     = 10;
  localparam logic [2:0] STRAP = 3'b011;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic bd_we = 1'b0;
  logic [7:0] bd_addr = '0, bd_data = '0;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] a_mdl;

  always #2.5 clk = ~clk;

  i2c_eeprom_rd #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni, .strap_i(STRAP), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .bd_we_i(bd_we), .bd_addr_i(bd_addr), .bd_data_i(bd_data)
  );

  // {random, word address, byte count}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 16'h0000, 4'd2},
    {1'b1, 16'h0010, 4'd3},
    {1'b0, 16'h0000, 4'd1},
    {1'b1, 16'hAB05, 4'd2},
    {1'b1, 16'h00FE, 4'd4},
    {1'b0, 16'h0000, 4'd3}
  };

  function automatic logic [7:0] pat(int i);
    return 8'(((i * 37) + 11) ^ (i >> 3));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic read_bit(output logic b);
    logic b0;
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    b0 = sda_bus; wq(); b = sda_bus;
    chk(b0 == b, "R10", b, b0);
    m_scl = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(ack);
  endtask

  task automatic read_byte(output logic [7:0] d, input bit m_ack);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    send_bit(~m_ack);
  endtask

  task automatic load_addr(input logic [15:0] wa);
    logic ack;
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, ack); chk(ack == 1'b0, "R2", ack, 0);
    write_byte(wa[15:8], ack);               chk(ack == 1'b0, "R5", ack, 0);
    write_byte(wa[7:0], ack);                chk(ack == 1'b0, "R5", ack, 0);
    a_mdl = wa[7:0];
  endtask

  task automatic read_run(input int n, input string req, input bit do_stop);
    logic ack;
    logic [7:0] d;
    bus_start();
    write_byte({4'b1010, STRAP, 1'b1}, ack); chk(ack == 1'b0, "R2", ack, 0);
    for (int k = 0; k < n; k++) begin
      read_byte(d, k < n - 1);
      chk(d == mdl[a_mdl], req, d, mdl[a_mdl]);
      a_mdl = a_mdl + 8'd1;
    end
    chk(sda_oe == 1'b0, "R8", sda_oe, 0);
    if (do_stop) bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) mdl[i] = pat(i);
    // preload through the sideband port while reset is held
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      bd_we = 1'b1; bd_addr = 8'(i); bd_data = pat(i);
    end
    @(negedge clk); bd_we = 1'b0;
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    rst_ni = 1'b1;
    wq();
    chk(sda_bus == 1'b1, "R1", sda_bus, 1);
    a_mdl = 8'd0;

    // table walk: R1 first pointer read, R4 pointer reads, R5/R6/R7
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][20]) begin
        load_addr(VEC[v][19:4]);
        read_run(int'(VEC[v][3:0]), (VEC[v][19:4] == 16'h00FE) ? "R7" : "R6", 1'b1);
      end else begin
        read_run(int'(VEC[v][3:0]), (v == 0) ? "R1" : "R4", 1'b1);
      end
    end

    // R3: foreign device byte, line stays released
    bus_start();
    write_byte({4'b1010, 3'b101, 1'b1}, ack);
    chk(ack == 1'b1, "R3", ack, 1);
    read_byte(d, 1'b0);
    chk(d == 8'hFF, "R3", d, 8'hFF);
    bus_stop();
    read_run(1, "R3", 1'b1);

    // R9: STOP inside high address byte, pointer unchanged
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, ack); chk(ack == 1'b0, "R2", ack, 0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    read_run(1, "R9", 1'b1);

    // R9: repeated START inside low address byte, pointer unchanged
    bus_start();
    write_byte({4'b1010, STRAP, 1'b0}, ack);
    write_byte(8'h00, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    read_run(2, "R9", 1'b1);

    // R8: NACK followed directly by START
    read_run(1, "R8", 1'b0);
    read_run(2, "R8", 1'b1);

    // R11: sideband write then bus read
    @(negedge clk);
    bd_we = 1'b1; bd_addr = 8'h20; bd_data = 8'h3C;
    @(negedge clk);
    bd_we = 1'b0;
    mdl[8'h20] = 8'h3C;
    load_addr(16'h0020);
    read_run(1, "R11", 1'b1);

    // R7: pointer read across the top of the array
    load_addr(16'h00FF);
    read_run(2, "R7", 1'b1);
    read_run(1, "R7", 1'b1);

    wq();
    finish_run();
  end
endmodule